// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Output Compare Channel

This block is a free-running up-counter fed by a programmable clock divider. The counter runs from zero to a period limit and wraps. One compare channel watches the counter. When the counter reaches the compare value, the channel changes its output level according to a match action that can be changed at run time. The three possible actions are: invert the level, force the level to active, or force it to inactive. The pin level can drive a lamp or a similar load directly, and a polarity input selects whether active means high or low.

The divider, period and compare settings come in on plain input buses that act as preload values. They are copied into working registers only on the first enabled cycle after reset and at every counter wrap, so a period in progress is never shortened. A one-cycle pulse marks each compare match and another marks each wrap.

Two small state machines make up the block. The timer sequencer has two states. `TS_LOAD` is the first enabled cycle after reset: it copies the settings and moves to `TS_RUN` through the transition *prime*. `TS_RUN` counts and stays in place; its *tick* and *wrap* events are named in R3 and R4. The channel machine also has two states, `OL_IDLE` (inactive level) and `OL_ACTIVE` (active level). On a match it moves between them through three transitions: *flip* in toggle mode, *raise* in set-active mode and *drop* in set-inactive mode.

Top module: `cmp_timer`

## Requirements
- R1: While reset is held and just after it is released, `oc_out` equals `pol_inv` (inactive level), `match_pulse` and `update_pulse` are 0, and the match action is toggle.
- R2: The first cycle with `cnt_en` high after reset only loads `psc_in`, `arr_in` and `cmp_in` into the working registers. Counting starts on the next enabled cycle with the counter at 0.
- R3: The counter advances by one after every PSC+1 enabled cycles (one *tick*), where PSC is the loaded divider value.
- R4: When a tick finds the counter equal to the loaded period limit ARR, the counter returns to 0 (*wrap*). `update_pulse` is high for exactly the one cycle after that clock edge, which gives a period of (ARR+1)·(PSC+1) enabled cycles.
- R5: A match occurs once per counter value, on the first divider cycle of that value, when the counter equals the loaded compare value. `match_pulse` is high for the one cycle after the match edge. A compare value above ARR never matches.
- R6: Match action code 2'b00 (toggle) inverts the output level on each match.
- R7: Match action code 2'b01 drives the level to active on a match, and the level stays active afterwards.
- R8: Match action code 2'b10 drives the level to inactive on a match. Code 2'b11 leaves the level unchanged.
- R9: A `mode_wr` pulse stores `mode_in`, and the stored action governs matches from the next cycle on. A write in the same cycle as a match does not affect that match.
- R10: Changes to `psc_in`, `arr_in` or `cmp_in` have no effect until the next wrap, or until the load cycle of R2.
- R11: While `cnt_en` is low, the divider and the counter hold their values and no match or wrap occurs.
- R12: `oc_out` is the channel level XOR `pol_inv`, and a change of `pol_inv` shows at the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Enables the divider and the counter |
| psc_in | input | PSC_W | Divider preload value (divides by value+1) |
| arr_in | input | CNT_W | Period limit preload value |
| cmp_in | input | CNT_W | Compare value preload |
| mode_wr | input | 1 | Stores `mode_in` as the match action |
| mode_in | input | 2 | Match action code: 00 toggle, 01 set active, 10 set inactive, 11 hold |
| pol_inv | input | 1 | 1 makes the active level low on the pin |
| oc_out | output | 1 | Channel output pin |
| match_pulse | output | 1 | One-cycle compare match pulse |
| update_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The assertions assume that reset is applied before any enable and that the settings buses carry known values whenever `cnt_en` is high. They also assume `mode_in` carries a known code on every write. The stimulus applies reset with all buses set and then changes inputs only on the falling clock edge. The 2-bit action field has no unused values, so every code that the pseudo-random mode writes produce is legal. Divider and period values are kept small so that many wraps, matches and mid-period setting changes fit in a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        OC_TOGGLE    = 2'b00,
        OC_SET_ACT   = 2'b01,
        OC_SET_INACT = 2'b10,
        OC_HOLD      = 2'b11
    } oc_mode_e;

    typedef enum logic {
        TS_LOAD = 1'b0,
        TS_RUN  = 1'b1
    } tmr_state_e;

    typedef enum logic {
        OL_IDLE   = 1'b0,
        OL_ACTIVE = 1'b1
    } oc_lvl_e;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
    import tmr_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             match_o,
    output logic             update_o
);
    localparam logic [PSC_W-1:0] PRE_ONE = PSC_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [PSC_W-1:0] pre_q, psc_q;
    logic [CNT_W-1:0] cnt_q, arr_q, cmp_q;
    logic             tick, wrap, load;

    assign tick    = (state_q == TS_RUN) && en_i && (pre_q == psc_q);
    assign wrap    = tick && (cnt_q == arr_q);
    assign load    = en_i && ((state_q == TS_LOAD) || wrap);
    assign match_o = (state_q == TS_RUN) && en_i && (pre_q == '0) && (cnt_q == cmp_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_LOAD: if (en_i) state_d = TS_RUN;   // prime
            TS_RUN:  state_d = TS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_LOAD;
        else        state_q <= state_d;
    end

    // datapath and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            cnt_q    <= '0;
            psc_q    <= '0;
            arr_q    <= '0;
            cmp_q    <= '0;
            update_o <= 1'b0;
        end else begin
            update_o <= wrap;
            if (load) begin
                psc_q <= psc_i;
                arr_q <= arr_i;
                cmp_q <= cmp_i;
            end
            if (state_q == TS_RUN && en_i) begin
                if (tick) begin
                    pre_q <= '0;
                    cnt_q <= wrap ? '0 : cnt_q + CNT_ONE;
                end else begin
                    pre_q <= pre_q + PRE_ONE;
                end
            end
        end
    end

    a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cnt_q) && $stable(pre_q)));
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_RUN) |-> (cnt_q <= arr_q));
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (cnt_q == '0));
    a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_RUN) |-> (pre_q <= psc_q));
endmodule

// File: rtl/oc_chan.sv
module oc_chan
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_i,
    output logic       lvl_o,
    output logic       match_o
);
    oc_mode_e mode_q;
    oc_lvl_e  lvl_q, lvl_d;

    // next-state logic: flip / raise / drop
    always_comb begin
        lvl_d = lvl_q;
        if (match_i) begin
            unique case (mode_q)
                OC_TOGGLE:    lvl_d = (lvl_q == OL_ACTIVE) ? OL_IDLE : OL_ACTIVE;
                OC_SET_ACT:   lvl_d = OL_ACTIVE;
                OC_SET_INACT: lvl_d = OL_IDLE;
                OC_HOLD:      lvl_d = lvl_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= OL_IDLE;
        else        lvl_q <= lvl_d;
    end

    // action register and match pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= OC_TOGGLE;
            match_o <= 1'b0;
        end else begin
            match_o <= match_i;
            if (mode_wr_i) mode_q <= oc_mode_e'(mode_i);
        end
    end

    assign lvl_o = (lvl_q == OL_ACTIVE);

    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_q == OC_TOGGLE) |=> (lvl_q != $past(lvl_q)));
    a_r7_set_active: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_q == OC_SET_ACT) |=> (lvl_q == OL_ACTIVE));
    a_r8_set_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_q == OC_SET_INACT) |=> (lvl_q == OL_IDLE));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i || mode_q == OC_HOLD) |=> $stable(lvl_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] arr_in,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             mode_wr,
    input  logic [1:0]       mode_in,
    input  logic             pol_inv,
    output logic             oc_out,
    output logic             match_pulse,
    output logic             update_pulse
);
    logic match_evt, lvl;

    tmr_ctl #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cnt_en),
        .psc_i    (psc_in),
        .arr_i    (arr_in),
        .cmp_i    (cmp_in),
        .match_o  (match_evt),
        .update_o (update_pulse)
    );

    oc_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_i   (match_evt),
        .mode_wr_i (mode_wr),
        .mode_i    (mode_in),
        .lvl_o     (lvl),
        .match_o   (match_pulse)
    );

    assign oc_out = lvl ^ pol_inv;

    a_r12_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lvl) && $changed(pol_inv)) |-> $changed(oc_out));
endmodule

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
    localparam int PSC_W = 16;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [PSC_W-1:0] psc_in = '0;
    logic [CNT_W-1:0] arr_in = '0;
    logic [CNT_W-1:0] cmp_in = '0;
    logic mode_wr = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic pol_inv = 1'b0;
    logic oc_out, match_pulse, update_pulse;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R1";

    // behavioural reference state
    bit m_loaded;
    int m_pre, m_cnt, m_psc, m_arr, m_cmp, m_mode;
    bit m_lvl, m_mp, m_up;

    always #2.5 clk = ~clk;

    cmp_timer #(.PSC_W(PSC_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .psc_in(psc_in), .arr_in(arr_in), .cmp_in(cmp_in),
        .mode_wr(mode_wr), .mode_in(mode_in), .pol_inv(pol_inv),
        .oc_out(oc_out), .match_pulse(match_pulse), .update_pulse(update_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_loaded = 0; m_pre = 0; m_cnt = 0; m_psc = 0; m_arr = 0; m_cmp = 0;
            m_mode = 0; m_lvl = 0; m_mp = 0; m_up = 0;
        end else begin
            m_mp = 0; m_up = 0;
            if (cnt_en) begin
                if (!m_loaded) begin
                    m_loaded = 1;
                    m_psc = psc_in; m_arr = arr_in; m_cmp = cmp_in;
                end else begin
                    if (m_pre == 0 && m_cnt == m_cmp) begin
                        m_mp = 1;
                        if (m_mode == 0) m_lvl = !m_lvl;
                        else if (m_mode == 1) m_lvl = 1;
                        else if (m_mode == 2) m_lvl = 0;
                    end
                    if (m_pre == m_psc) begin
                        m_pre = 0;
                        if (m_cnt == m_arr) begin
                            m_cnt = 0; m_up = 1;
                            m_psc = psc_in; m_arr = arr_in; m_cmp = cmp_in;
                        end else m_cnt = m_cnt + 1;
                    end else m_pre = m_pre + 1;
                end
            end
            if (mode_wr) m_mode = mode_in;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
            $finish;
        end
    end

    task automatic check1(string what, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check1("oc_out", oc_out, m_lvl ^ pol_inv);
            check1("match_pulse", match_pulse, m_mp);
            check1("update_pulse", update_pulse, m_up);
        end
    endtask

    task automatic set_mode(int code);
        mode_in = code[1:0];
        mode_wr = 1'b1;
        step(1);
        mode_wr = 1'b0;
    endtask

    initial begin
        logic [7:0] lf = 8'hA5;
        // R1: reset state
        tag = "R1";
        psc_in = 0; arr_in = 9; cmp_in = 4;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R2: load cycle then counting; R4 wrap, R5 match, R6 toggle
        tag = "R2";
        cnt_en = 1'b1;
        step(3);
        tag = "R6";
        step(40);
        // R10: mid-period change waits for wrap; R3 divider
        tag = "R10";
        psc_in = 2; arr_in = 5; cmp_in = 3;
        step(8);
        tag = "R3";
        step(60);
        tag = "R4";
        psc_in = 1; arr_in = 7; cmp_in = 0;
        step(50);
        // R7 set active, R8 set inactive and hold
        tag = "R7";
        set_mode(1);
        step(50);
        tag = "R8";
        set_mode(2);
        step(40);
        set_mode(1);
        step(20);
        set_mode(3);
        step(40);
        // R5: compare above period never matches
        tag = "R5";
        set_mode(0);
        cmp_in = 12;
        step(60);
        cmp_in = 2; psc_in = 0; arr_in = 4;
        step(20);
        // R11: enable low freezes
        tag = "R11";
        cnt_en = 1'b0;
        step(15);
        cnt_en = 1'b1;
        step(10);
        // R12: polarity
        tag = "R12";
        pol_inv = 1'b1;
        step(12);
        pol_inv = 1'b0;
        step(6);
        // R9: pseudo-random mode writes, some coinciding with matches
        tag = "R9";
        psc_in = 0; arr_in = 3; cmp_in = 1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mode_in = lf[1:0];
            mode_wr = lf[2] & lf[6];
            cnt_en = (lf[7:5] != 3'b000);
            if (lf[4:0] == 5'd9) arr_in = CNT_W'(lf[7:6]) + 1;
            step(1);
        end
        mode_wr = 1'b0;
        cnt_en = 1'b1;
        step(10);
        summary();
        $finish;
    end
endmodule